// File: doc/BRIEF.md
# Dual-Clock Sample FIFO Controller

This block carries a continuous stream of sample words from the clock that delivers the data into the clock that converts them, through an eight-word FIFO. The read side advances one word per conversion cycle once the block is calibrated. It measures how many words sit between the write and read pointers, smooths that count, and reports it as the added latency in conversion cycles.

Calibration does not move a pointer. The reader stops and resumes only when the count of words held has reached a programmed target. After that, drift is handled under one of three modes. In manual mode an external controller asks for single hold cycles. In surveillance mode a drift outside the threshold band only raises an interrupt. In automatic mode the block inserts hold cycles by itself. A hold cycle reads nothing and marks the output as not new, so a correction never loses or repeats a word.

A stopped input data clock freezes the write pointer as seen from the conversion side. A counter detects this and flags it, because the converter downstream would otherwise keep replaying stale samples without any warning.

Top module: `smp_xfer_ctrl`

## Requirements
- R1: Every accepted word leaves on `rd_data` exactly once and in write order. `rd_valid` is high for one cycle per word, and `rd_data` holds its value while `rd_valid` is low.
- R2: The FIFO holds 2^AW words (8 by default). A write that arrives while the FIFO is full is ignored.
- R3: After reset the reader is idle (`rd_valid` 0, `calibrated` 0). A `cal_req` pulse clears `calibrated`. Reading starts, and `calibrated` rises, in the first cycle in which the count of words held is at least `target`.
- R4: `latency` is the average, rounded down, of the count of words held over the last 2^AVG_SH conversion cycles. With equal write and read rates it settles at the calibrated count.
- R5: In automatic mode (`mode` = 2'b10), a calibrated block whose `latency` is below `thr_lo` inserts one hold cycle. A hold cycle performs no read. After each hold the block waits 2*2^AVG_SH cycles before it may insert another, and the holds raise the count to `thr_lo`.
- R6: `drift_err` is high when `calibrated` is 1 and `latency` lies outside [`thr_lo`, `thr_hi`], in every mode.
- R7: In surveillance mode (`mode` 2'b01 or 2'b11), `drift_err` sets `irq` and no hold cycle is ever inserted.
- R8: In manual mode (`mode` = 2'b00), each cycle of `manual_hold` inserts one hold cycle, and `drift_err` does not set `irq`.
- R9: `irq` stays set until a cycle with `irq_clr` high and no new set condition.
- R10: `clk_lost` rises once the synchronized write pointer has stayed unchanged for more than `miss_limit` conversion cycles. The same rise sets `irq`. `clk_lost` clears when the pointer moves again.
- R11: After reset, `rd_valid`, `latency`, `calibrated`, `drift_err`, `clk_lost` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Input data clock |
| wrst_n | input | 1 | Active-low reset, write side |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Sample word to write |
| rclk | input | 1 | Conversion clock |
| rrst_n | input | 1 | Active-low reset, read side |
| mode | input | 2 | 00 manual, 01/11 surveillance, 10 automatic |
| cal_req | input | 1 | Calibration request pulse |
| target | input | AW+1 | Count of words held at which reading starts |
| thr_lo | input | AW+1 | Lower latency threshold |
| thr_hi | input | AW+1 | Upper latency threshold |
| manual_hold | input | 1 | Hold request in manual mode |
| miss_limit | input | MW | Idle cycles tolerated before `clk_lost` |
| irq_clr | input | 1 | Clears the interrupt |
| rd_data | output | DW | Output sample word |
| rd_valid | output | 1 | A new word is on `rd_data` |
| latency | output | AW+1 | Averaged added latency in conversion cycles |
| calibrated | output | 1 | Calibration complete |
| drift_err | output | 1 | Latency outside the threshold band |
| clk_lost | output | 1 | Input data clock considered stopped |
| irq | output | 1 | Sticky interrupt |

## Verification
A read pointer that skips or stalls in the wrong cycle appears at the ports as soon as the next valid word carries the wrong value. The bench's word-by-word queue comparison therefore catches it at the first affected word. A wrong occupancy count or a faulty average does not show on the data at all. It shows only in `latency` and `drift_err`, after the 2^AVG_SH-cycle window has filled. It also shows in the number of hold gaps that the automatic mode inserts, which the bench counts against the number it expects. A broken idle counter shows only as `clk_lost` rising too early or too late relative to `miss_limit`, so the bench samples it on both sides of that limit.

// File: rtl/smp_xfer_ctrl.sv
module smp_xfer_ctrl #(
  parameter int DW     = 14,
  parameter int AW     = 3,
  parameter int AVG_SH = 2,
  parameter int MW     = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [1:0]    mode,
  input  logic          cal_req,
  input  logic [AW:0]   target,
  input  logic [AW:0]   thr_lo,
  input  logic [AW:0]   thr_hi,
  input  logic          manual_hold,
  input  logic [MW-1:0] miss_limit,
  input  logic          irq_clr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW:0]   latency,
  output logic          calibrated,
  output logic          drift_err,
  output logic          clk_lost,
  output logic          irq
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int NAVG  = 1 << AVG_SH;
  localparam int SW    = PW + AVG_SH;
  localparam int CW    = AVG_SH + 2;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write side
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic          full, wpush;

  assign full  = (wbin - g2b(rg_s2)) == PW'(DEPTH);
  assign wpush = wr_en && !full;

  always_ff @(posedge wclk) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rbin_gray_q;
      rg_s2 <= rg_s1;
      if (wpush) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk)
    if (wpush) mem[wbin[AW-1:0]] <= wr_data;

  // read side
  logic [PW-1:0] wg_s1, wg_s2, wg_prev, rbin, rbin_gray_q, occ;
  logic [PW-1:0] hist [NAVG];
  logic [SW-1:0] sum;
  logic [CW-1:0] cool;
  logic [MW-1:0] miss_cnt;
  logic          cal_pend, auto_fix, man_fix, armed, pop, wr_moved, miss_hit, notify;

  assign occ      = g2b(wg_s2) - rbin;
  assign latency  = PW'(sum >> AVG_SH);
  assign drift_err = calibrated && (latency < thr_lo || latency > thr_hi);
  assign notify   = mode != 2'b00;
  assign auto_fix = mode == 2'b10 && calibrated && latency < thr_lo && cool == '0;
  assign man_fix  = mode == 2'b00 && calibrated && manual_hold;
  assign armed    = calibrated || (cal_pend && occ >= target);
  assign pop      = armed && occ != '0 && !auto_fix && !man_fix;
  assign wr_moved = wg_s2 != wg_prev;
  assign miss_hit = !wr_moved && !clk_lost && miss_cnt == miss_limit;

  always_ff @(posedge rclk) begin
    if (!rrst_n) begin
      wg_s1       <= '0;
      wg_s2       <= '0;
      wg_prev     <= '0;
      rbin        <= '0;
      rbin_gray_q <= '0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      calibrated  <= 1'b0;
      cal_pend    <= 1'b0;
      sum         <= '0;
      cool        <= '0;
      miss_cnt    <= '0;
      clk_lost    <= 1'b0;
      irq         <= 1'b0;
      for (int i = 0; i < NAVG; i++) hist[i] <= '0;
    end else begin
      wg_s1   <= wgray;
      wg_s2   <= wg_s1;
      wg_prev <= wg_s2;

      rd_valid <= pop;
      if (pop) begin
        rd_data     <= mem[rbin[AW-1:0]];
        rbin        <= rbin + 1'b1;
        rbin_gray_q <= b2g(rbin + 1'b1);
      end

      if (cal_req) begin
        calibrated <= 1'b0;
        cal_pend   <= 1'b1;
      end else if (cal_pend && occ >= target) begin
        calibrated <= 1'b1;
        cal_pend   <= 1'b0;
      end

      hist[0] <= occ;
      for (int i = 1; i < NAVG; i++) hist[i] <= hist[i-1];
      sum <= sum + SW'(occ) - SW'(hist[NAVG-1]);

      if (auto_fix)          cool <= CW'(2 * NAVG - 1);
      else if (cool != '0)   cool <= cool - 1'b1;

      if (wr_moved) begin
        miss_cnt <= '0;
        clk_lost <= 1'b0;
      end else if (miss_cnt == miss_limit) begin
        clk_lost <= 1'b1;
      end else begin
        miss_cnt <= miss_cnt + 1'b1;
      end

      irq <= miss_hit || (notify && drift_err) || (irq && !irq_clr);
    end
  end
endmodule

// File: rtl/smp_xfer_chk.sv
module smp_xfer_chk #(
  parameter int DW = 14,
  parameter int AW = 3
) (
  input logic          rclk,
  input logic          rrst_n,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   occ,
  input logic [AW:0]   rbin,
  input logic [AW:0]   latency,
  input logic          calibrated,
  input logic          cal_pend,
  input logic          clk_lost,
  input logic          irq
);
  localparam int DEPTH = 1 << AW;

  // R1
  word_avail_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_valid |-> $past(occ) != '0);

  // R1
  data_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_valid |-> $stable(rd_data));

  // R1
  no_skip_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rbin == $past(rbin)) || (rbin == $past(rbin) + 1'b1));

  // R2
  no_overflow_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    occ <= (AW+1)'(DEPTH));

  // R3
  idle_precal_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!calibrated && !cal_pend) |=> !rd_valid);

  // R4
  latency_range_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    latency <= (AW+1)'(DEPTH));

  // R10
  lost_irq_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(clk_lost) |-> irq);
endmodule

bind smp_xfer_ctrl smp_xfer_chk #(.DW(DW), .AW(AW)) u_chk (
  .rclk(rclk), .rrst_n(rrst_n), .rd_valid(rd_valid), .rd_data(rd_data),
  .occ(occ), .rbin(rbin), .latency(latency), .calibrated(calibrated),
  .cal_pend(cal_pend), .clk_lost(clk_lost), .irq(irq)
);

// File: tb/sim_smp_xfer_ctrl.sv
module sim_smp_xfer_ctrl;
  localparam int DW = 14;
  localparam int AW = 3;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0, wr_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] mode = 2'b00;
  logic cal_req = 0, manual_hold = 0, irq_clr = 0;
  logic [AW:0] target = 4, thr_lo = 0, thr_hi = 8;
  logic [7:0] miss_limit = 20;
  logic [DW-1:0] rd_data;
  logic rd_valid, calibrated, drift_err, clk_lost, irq;
  logic [AW:0] latency;

  always #2 rclk = ~rclk;
  initial begin #1; forever #2 wclk = ~wclk; end

  smp_xfer_ctrl #(.DW(DW), .AW(AW)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .mode(mode), .cal_req(cal_req),
    .target(target), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .manual_hold(manual_hold), .miss_limit(miss_limit), .irq_clr(irq_clr),
    .rd_data(rd_data), .rd_valid(rd_valid), .latency(latency),
    .calibrated(calibrated), .drift_err(drift_err), .clk_lost(clk_lost), .irq(irq));

  int checks = 0, errors = 0, nxt = 0, push_lim = 8, gaps = 0, nreads = 0;
  int q[$];
  bit wr_on = 0, done = 0;
  logic [DW-1:0] last_data = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rcyc(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic pulse_cal();
    cal_req = 1; rcyc(1); cal_req = 0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1; rcyc(1); irq_clr = 0;
  endtask

  // writer: one word per data clock while enabled; the model queue keeps the accepted words
  initial forever begin
    @(negedge wclk);
    if (wr_on) begin
      wr_en = 1;
      wr_data = DW'(nxt);
      if (nxt < push_lim) q.push_back(nxt);
      nxt++;
    end else wr_en = 0;
  end

  // reference comparison on every conversion clock
  initial forever begin
    @(negedge rclk);
    if (rrst_n) begin
      if (rd_valid) begin
        nreads++;
        if (q.size() == 0) chk(0, "R1 word with empty model", int'(rd_data), -1);
        else begin
          int e;
          e = q.pop_front();
          chk(rd_data == DW'(e), "R1 order", int'(rd_data), e);
        end
      end else begin
        if (rd_data !== last_data) chk(0, "R1 hold while not valid", int'(rd_data), int'(last_data));
        if (calibrated) gaps++;
      end
      last_data = rd_data;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rcyc(3);
    wrst_n = 1; rrst_n = 1;
    rcyc(1);
    chk(rd_valid == 0, "R11 rd_valid", rd_valid, 0);
    chk(latency == 0, "R11 latency", latency, 0);
    chk(calibrated == 0, "R11 calibrated", calibrated, 0);
    chk(drift_err == 0, "R11 drift_err", drift_err, 0);
    chk(clk_lost == 0, "R11 clk_lost", clk_lost, 0);
    chk(irq == 0, "R11 irq", irq, 0);

    // burst of 12 into an idle reader: only 8 kept
    @(posedge wclk) wr_on = 1;
    wait (nxt == 12);
    wr_on = 0;
    rcyc(10);
    chk(nreads == 0, "R3 reader idle before calibration", nreads, 0);
    chk(latency == 8, "R2 full FIFO latency", latency, 8);
    target = 4;
    pulse_cal();
    rcyc(20);
    chk(nreads == 8, "R2 words kept", nreads, 8);
    chk(q.size() == 0, "R2 model drained", q.size(), 0);
    chk(calibrated == 1, "R3 calibrated", calibrated, 1);

    // recalibrate on an empty FIFO, then stream
    target = 2;
    pulse_cal();
    chk(calibrated == 0, "R3 cleared by request", calibrated, 0);
    push_lim = 1 << 30;
    nxt = 100;
    @(posedge wclk) wr_on = 1;
    rcyc(40);
    chk(calibrated == 1, "R3 calibrated at target", calibrated, 1);
    chk(latency == 2, "R4 settled latency", latency, 2);
    chk(drift_err == 0, "R6 in band", drift_err, 0);
    pulse_clr();
    rcyc(2);
    chk(irq == 0, "R9 cleared", irq, 0);

    // manual mode: drift flagged but no interrupt
    thr_hi = 1;
    rcyc(10);
    chk(drift_err == 1, "R6 above band", drift_err, 1);
    chk(irq == 0, "R8 no irq in manual", irq, 0);
    thr_hi = 8;
    rcyc(10);
    chk(drift_err == 0, "R6 back in band", drift_err, 0);

    // manual hold
    gaps = 0;
    manual_hold = 1; rcyc(1); manual_hold = 0;
    rcyc(20);
    chk(gaps == 1, "R8 one hold", gaps, 1);
    chk(latency == 3, "R4 latency after hold", latency, 3);

    // automatic correction after a 2-word write pause
    mode = 2'b10; thr_lo = 3;
    rcyc(10);
    gaps = 0;
    @(posedge wclk) wr_on = 0;
    repeat (2) @(posedge wclk);
    wr_on = 1;
    rcyc(60);
    chk(gaps == 2, "R5 holds inserted", gaps, 2);
    chk(latency == 3, "R5 restored latency", latency, 3);
    chk(drift_err == 0, "R6 restored", drift_err, 0);

    // surveillance
    mode = 2'b01;
    pulse_clr();
    rcyc(2);
    chk(irq == 0, "R9 cleared", irq, 0);
    gaps = 0;
    thr_hi = 2;
    rcyc(20);
    chk(drift_err == 1, "R6 surveillance drift", drift_err, 1);
    chk(irq == 1, "R7 irq raised", irq, 1);
    chk(gaps == 0, "R7 no holds", gaps, 0);
    chk(latency == 3, "R7 latency untouched", latency, 3);
    thr_hi = 8; thr_lo = 0; mode = 2'b00;
    rcyc(5);
    chk(irq == 1, "R9 sticky", irq, 1);
    pulse_clr();
    rcyc(2);
    chk(irq == 0, "R9 cleared by irq_clr", irq, 0);

    // stopped data clock
    @(posedge wclk) wr_on = 0;
    rcyc(12);
    chk(clk_lost == 0, "R10 below limit", clk_lost, 0);
    rcyc(30);
    chk(clk_lost == 1, "R10 beyond limit", clk_lost, 1);
    chk(irq == 1, "R10 irq", irq, 1);
    @(posedge wclk) wr_on = 1;
    rcyc(10);
    chk(clk_lost == 0, "R10 cleared on restart", clk_lost, 0);

    @(posedge wclk) wr_on = 0;
    rcyc(20);
    chk(q.size() == 0, "R1 every word delivered", q.size(), 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule